// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control state machine for a non-pipelined 32-bit load/store processor. The processor uses a single memory port for both instruction fetch and data access. The datapath around it holds the program counter, an instruction register, two operand registers, an ALU result register, a memory data register and the register file. Every cycle the sequencer drives the datapath's strobes and multiplexer selects. It does this from its current step, the 6-bit opcode held in the instruction register, the 6-bit function field, and the ALU condition flag.

Every instruction begins with the same two steps: a fetch, which also advances the PC by four, and a decode, which reads two registers whatever the instruction is. After decode the path depends on the opcode:
- Loads take five cycles.
- Stores and register-to-register operations take four.
- Conditional branches and jumps take three.
- An opcode the block does not recognise takes two cycles and writes nothing.

Branches finish in their execute step. A dedicated target adder feeds the PC, and the PC is loaded only when the ALU reports equality. Most outputs are decoded from the state alone. Only two are not: the branch PC write, which is qualified by the condition flag, and the ALU code during register execute, which is taken from the function field.

Top module: `mcyc_ctrl_seq`

## Requirements
- R1: In the fetch step, mem_rd, ir_we and pc_we are 1 and addr_sel is 0. pc_src is 00 (increment), alu_op is 010, and every other output is 0.
- R2: Pulling rst_n low puts the block in fetch at once, without waiting for a clock edge. After rst_n rises, the block stays in fetch through the next two rising edges and enters decode on the third.
- R3: In the decode step every output is 0 except alu_op, which is 010. The opcode sampled at the end of decode selects the next step: 100011 load, 101011 store, 000000 register op, 000100 branch, 000010 jump. Any other opcode returns the block to fetch.
- R4: Load steps, after decode:
  - Address step: alub_sel is 1 (immediate) and alu_op is 010.
  - Memory step: mem_rd and addr_sel are 1.
  - Write-back step: reg_we and wb_sel are 1 and dst_sel is 0.
  - The block then returns to fetch.
- R5: Store steps, after decode:
  - Address step: the same as for a load.
  - Memory step: mem_wr and addr_sel are 1 and mem_rd is 0.
  - The block then returns to fetch.
- R6: A register op executes with alub_sel at 0. It then completes with reg_we and dst_sel at 1 and wb_sel at 0, and the block returns to fetch.
- R7: In register execute, alu_op follows the function field:
  - 100000 gives 010.
  - 100010 gives 110.
  - 100100 gives 000.
  - 100101 gives 001.
  - 101010 gives 111.
  - Any other value gives 010.
- R8: A branch completes in one step with alu_op 110 and pc_src 01 (target adder), and pc_we equal to alu_cond in that same cycle. The block then returns to fetch.
- R9: A jump completes in one step with pc_we at 1 and pc_src 10 (jump target). The block then returns to fetch.
- R10: Inputs have no effect outside the steps that use them. The opcode is used only in decode and in the address step, funct only in register execute, and alu_cond only in branch completion.
- R11: mem_rd and mem_wr are never 1 in the same cycle. Outside register execute and branch completion, alu_op is 010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field from the instruction register |
| funct | input | 6 | Function field from the instruction register |
| alu_cond | input | 1 | ALU equality flag |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address source: 0 PC, 1 ALU result register |
| ir_we | output | 1 | Instruction register write enable |
| pc_we | output | 1 | Program counter write enable |
| pc_src | output | 2 | PC source: 00 PC+4, 01 branch target, 10 jump target |
| alub_sel | output | 1 | ALU B input: 0 operand register B, 1 sign-extended immediate |
| alu_op | output | 3 | ALU operation code |
| dst_sel | output | 1 | Destination register field select |
| reg_we | output | 1 | Register file write enable |
| wb_sel | output | 1 | Write-back source: 0 ALU result, 1 memory data |

## Verification
Two decisions fall in the same cycle during branch completion: the equality compare selected by alu_op, and the PC load that depends on that compare through alu_cond. The bench sends branches with the flag both high and low in that cycle, and drives arbitrary flag values in every other cycle. A pc_we that follows the flag anywhere else, or fails to follow it in branch completion, therefore differs from the cycle-level model. A second collision is reset arriving in the middle of a load's memory step. That case is judged by sampling the outputs one nanosecond after the fall, before any clock edge.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  localparam int OPC_W  = 6;
  localparam int FN_W   = 6;
  localparam int AOP_W  = 3;
  localparam int PCS_W  = 2;

  // instruction opcodes
  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;

  // function field values for register ops
  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_AND = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

  // ALU operation codes
  localparam logic [AOP_W-1:0] AOP_AND = 3'b000;
  localparam logic [AOP_W-1:0] AOP_OR  = 3'b001;
  localparam logic [AOP_W-1:0] AOP_ADD = 3'b010;
  localparam logic [AOP_W-1:0] AOP_SUB = 3'b110;
  localparam logic [AOP_W-1:0] AOP_SLT = 3'b111;

  // PC source select
  localparam logic [PCS_W-1:0] PCS_INC    = 2'b00;
  localparam logic [PCS_W-1:0] PCS_BRANCH = 2'b01;
  localparam logic [PCS_W-1:0] PCS_JUMP   = 2'b10;

  typedef enum logic [3:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_LDMEM  = 4'd3,
    ST_LDWB   = 4'd4,
    ST_STMEM  = 4'd5,
    ST_REXEC  = 4'd6,
    ST_RDONE  = 4'd7,
    ST_BRANCH = 4'd8,
    ST_JUMP   = 4'd9
  } step_t;

  typedef struct packed {
    logic             mem_rd;
    logic             mem_wr;
    logic             addr_sel;
    logic             ir_we;
    logic             pc_we;
    logic [PCS_W-1:0] pc_src;
    logic             alub_sel;
    logic [AOP_W-1:0] alu_op;
    logic             dst_sel;
    logic             reg_we;
    logic             wb_sel;
  } ctrl_t;

endpackage

// File: rtl/mcyc_rst_sync.sv
module mcyc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mcyc_funct_dec.sv
module mcyc_funct_dec
  import mcyc_pkg::*;
(
  input  logic [FN_W-1:0]  funct,
  output logic [AOP_W-1:0] rop
);

  always_comb begin
    unique case (funct)
      FN_ADD:  rop = AOP_ADD;
      FN_SUB:  rop = AOP_SUB;
      FN_AND:  rop = AOP_AND;
      FN_OR:   rop = AOP_OR;
      FN_SLT:  rop = AOP_SLT;
      default: rop = AOP_ADD;
    endcase
  end

endmodule

// File: rtl/mcyc_next_state.sv
module mcyc_next_state
  import mcyc_pkg::*;
(
  input  step_t            cur,
  input  logic [OPC_W-1:0] opcode,
  output step_t            nxt
);

  always_comb begin
    nxt = ST_FETCH;
    unique case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        unique case (opcode)
          OPC_LOAD, OPC_STORE: nxt = ST_ADDR;
          OPC_RTYPE:           nxt = ST_REXEC;
          OPC_BEQ:             nxt = ST_BRANCH;
          OPC_JUMP:            nxt = ST_JUMP;
          default:             nxt = ST_FETCH;
        endcase
      end
      ST_ADDR:   nxt = (opcode == OPC_LOAD) ? ST_LDMEM : ST_STMEM;
      ST_LDMEM:  nxt = ST_LDWB;
      ST_REXEC:  nxt = ST_RDONE;
      default:   nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mcyc_out_dec.sv
module mcyc_out_dec
  import mcyc_pkg::*;
(
  input  step_t            cur,
  input  logic [AOP_W-1:0] rop,
  input  logic             alu_cond,
  output ctrl_t            ctl
);

  always_comb begin
    ctl        = '0;
    ctl.alu_op = AOP_ADD;
    ctl.pc_src = PCS_INC;
    unique case (cur)
      ST_FETCH: begin
        ctl.mem_rd = 1'b1;
        ctl.ir_we  = 1'b1;
        ctl.pc_we  = 1'b1;
      end
      ST_DECODE: ;
      ST_ADDR:   ctl.alub_sel = 1'b1;
      ST_LDMEM: begin
        ctl.mem_rd   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_LDWB: begin
        ctl.reg_we = 1'b1;
        ctl.wb_sel = 1'b1;
      end
      ST_STMEM: begin
        ctl.mem_wr   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_REXEC:  ctl.alu_op = rop;
      ST_RDONE: begin
        ctl.reg_we  = 1'b1;
        ctl.dst_sel = 1'b1;
      end
      ST_BRANCH: begin
        ctl.alu_op = AOP_SUB;
        ctl.pc_src = PCS_BRANCH;
        ctl.pc_we  = alu_cond;
      end
      ST_JUMP: begin
        ctl.pc_src = PCS_JUMP;
        ctl.pc_we  = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mcyc_ctrl_seq.sv
module mcyc_ctrl_seq #(
  parameter int RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic       alu_cond,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       addr_sel,
  output logic       ir_we,
  output logic       pc_we,
  output logic [1:0] pc_src,
  output logic       alub_sel,
  output logic [2:0] alu_op,
  output logic       dst_sel,
  output logic       reg_we,
  output logic       wb_sel
);
  import mcyc_pkg::*;

  logic             rst_sync_n;
  step_t            cur_q;
  step_t            nxt;
  logic [AOP_W-1:0] rop;
  ctrl_t            ctl;

  mcyc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mcyc_next_state u_nxt (
    .cur    (cur_q),
    .opcode (opcode),
    .nxt    (nxt)
  );

  mcyc_funct_dec u_fn (
    .funct (funct),
    .rop   (rop)
  );

  mcyc_out_dec u_out (
    .cur      (cur_q),
    .rop      (rop),
    .alu_cond (alu_cond),
    .ctl      (ctl)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cur_q <= ST_FETCH;
    else             cur_q <= nxt;
  end

  assign mem_rd   = ctl.mem_rd;
  assign mem_wr   = ctl.mem_wr;
  assign addr_sel = ctl.addr_sel;
  assign ir_we    = ctl.ir_we;
  assign pc_we    = ctl.pc_we;
  assign pc_src   = ctl.pc_src;
  assign alub_sel = ctl.alub_sel;
  assign alu_op   = ctl.alu_op;
  assign dst_sel  = ctl.dst_sel;
  assign reg_we   = ctl.reg_we;
  assign wb_sel   = ctl.wb_sel;

  // R11
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(mem_rd && mem_wr));

  // R8
  br_qual_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pc_we && pc_src == PCS_BRANCH) |-> alu_cond);

  // R3
  dec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ir_we |=> !(mem_rd || mem_wr || reg_we || pc_we || ir_we));

  // R4
  ld_wb_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_rd && addr_sel) |=> (reg_we && wb_sel && !dst_sel));

  // R5
  st_ret_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_wr |=> (ir_we && mem_rd && !addr_sel));

  // R6
  rw_ret_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_we |=> ir_we);

endmodule

// File: tb/mcyc_ctrl_seq_test.sv
`timescale 1ns/1ps
module mcyc_ctrl_seq_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] opcode;
  logic [5:0] funct;
  logic       alu_cond;
  logic       mem_rd, mem_wr, addr_sel, ir_we, pc_we, alub_sel, dst_sel, reg_we, wb_sel;
  logic [1:0] pc_src;
  logic [2:0] alu_op;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  mcyc_ctrl_seq uut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct), .alu_cond(alu_cond),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_we(ir_we),
    .pc_we(pc_we), .pc_src(pc_src), .alub_sel(alub_sel), .alu_op(alu_op),
    .dst_sel(dst_sel), .reg_we(reg_we), .wb_sel(wb_sel)
  );

  // instruction classes used by the model
  localparam int C_LD = 0, C_ST = 1, C_RR = 2, C_BR = 3, C_JP = 4, C_BAD = 5;

  function automatic logic [2:0] fmap(logic [5:0] f);
    case (f)
      6'b100000: return 3'b010;
      6'b100010: return 3'b110;
      6'b100100: return 3'b000;
      6'b100101: return 3'b001;
      6'b101010: return 3'b111;
      default:   return 3'b010;
    endcase
  endfunction

  function automatic int cls_len(int cls);
    case (cls)
      C_LD:    return 5;
      C_ST:    return 4;
      C_RR:    return 4;
      C_BAD:   return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [5:0] cls_opc(int cls, int seed);
    case (cls)
      C_LD:    return 6'b100011;
      C_ST:    return 6'b101011;
      C_RR:    return 6'b000000;
      C_BR:    return 6'b000100;
      C_JP:    return 6'b000010;
      default: return (seed % 12 < 6) ? 6'b001000 : 6'b111111;
    endcase
  endfunction

  // {mem_rd,mem_wr,addr_sel,ir_we,pc_we,pc_src,alub_sel,alu_op,dst_sel,reg_we,wb_sel}
  function automatic logic [13:0] expect_v(int cls, int s, logic c, logic [5:0] f);
    logic rd = 0, wr = 0, as = 0, ir = 0, pw = 0, bs = 0, ds = 0, rw = 0, wb = 0;
    logic [1:0] ps = 2'b00;
    logic [2:0] op = 3'b010;
    if (s == 0) begin
      rd = 1; ir = 1; pw = 1;
    end else if (s >= 2) begin
      case (cls)
        C_LD: if (s == 2) bs = 1; else if (s == 3) begin rd = 1; as = 1; end
              else begin rw = 1; wb = 1; end
        C_ST: if (s == 2) bs = 1; else begin wr = 1; as = 1; end
        C_RR: if (s == 2) op = fmap(f); else begin rw = 1; ds = 1; end
        C_BR: begin op = 3'b110; ps = 2'b01; pw = c; end
        C_JP: begin ps = 2'b10; pw = 1; end
        default: ;
      endcase
    end
    return {rd, wr, as, ir, pw, ps, bs, op, ds, rw, wb};
  endfunction

  function automatic string tag(int cls, int s);
    if (s == 0) return "R1";
    if (s == 1) return "R3";
    case (cls)
      C_LD:    return "R4 R10";
      C_ST:    return "R5 R10";
      C_RR:    return (s == 2) ? "R7 R10" : "R6 R10";
      C_BR:    return "R8 R10";
      default: return "R9 R10";
    endcase
  endfunction

  function automatic logic [13:0] actual_v();
    return {mem_rd, mem_wr, addr_sel, ir_we, pc_we, pc_src, alub_sel, alu_op, dst_sel, reg_we, wb_sel};
  endfunction

  task automatic check(string req, logic [13:0] act, logic [13:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: outputs actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_excl();
    n_chk++;
    if (mem_rd && mem_wr) begin
      n_err++;
      $display("FAIL R11: rd/wr actual=11 expected=not both at %0t", $time);
    end
  endtask

  // runs one instruction; called just after a falling edge; abort_at >= 0 pulls reset mid-way
  task automatic run_instr(int cls, logic [5:0] fn, logic c, int seed, int abort_at);
    logic [5:0] opc;
    opc = cls_opc(cls, seed);
    for (int s = 0; s < cls_len(cls); s++) begin
      if (s == abort_at) begin
        rst_n = 1'b0;
        #1;
        check("R2", actual_v(), expect_v(C_LD, 0, 1'b0, 6'd0));
        return;
      end
      opcode   = (s == 1 || (s == 2 && cls <= C_ST)) ? opc : 6'(seed * 11 + s * 7 + 3);
      funct    = (cls == C_RR && s == 2) ? fn : 6'(seed * 5 + s + 1);
      alu_cond = (cls == C_BR && s == 2) ? c : 1'(seed + s);
      #1;
      check(tag(cls, s), actual_v(), expect_v(cls, s, c, fn));
      check_excl();
      @(negedge clk);
    end
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R2", actual_v(), expect_v(C_LD, 0, 1'b0, 6'd0));
    @(negedge clk);
  endtask

  function automatic logic [5:0] fn_pick(int k);
    case (k % 7)
      0: return 6'b100000;
      1: return 6'b100010;
      2: return 6'b100100;
      3: return 6'b100101;
      4: return 6'b101010;
      5: return 6'b000111;
      default: return 6'b111000;
    endcase
  endfunction

  initial begin
    rst_n = 1'b0; opcode = 6'b000100; funct = 6'd0; alu_cond = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R2", actual_v(), expect_v(C_LD, 0, 1'b0, 6'd0));
    release_reset();
    for (int i = 0; i < 48; i++)
      run_instr(i % 6, fn_pick(i / 6), 1'((i / 6) % 2), i, -1);
    run_instr(C_LD, 6'd0, 1'b0, 99, 3);
    @(negedge clk); #1;
    check("R2", actual_v(), expect_v(C_LD, 0, 1'b0, 6'd0));
    release_reset();
    run_instr(C_JP, 6'd0, 1'b0, 7, -1);
    run_instr(C_BR, 6'd0, 1'b1, 8, -1);
    run_instr(C_BR, 6'd0, 1'b0, 9, -1);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule